// File: doc/BRIEF.md
# Signed-Amount Six-Mode Shifter

This block moves the bits of a WIDTH-bit word in one of six ways: logical, arithmetic or circular, each to the left or to the right. A 3-bit operation code picks the mode. The shift distance is a signed two's complement value, and a negative distance makes the block perform the opposite-direction operation of the same kind. An arithmetic move refills the vacated end with copies of the bit at the opposite end of the word: the sign bit for a right move, the original lowest bit for a left move.

The datapath is combinational. It decodes the signed distance into a direction and a magnitude, passes the word through a logarithmic rotator, and then overwrites the vacated positions with the fill value. A parameter adds one output register. When that register is present, a synchronous active-high reset clears it. The block has no flow control, so a new word can be presented on every cycle.

Top module: `shifter_six_mode`

## Requirements
- R1: Opcode 000 shifts left logically and opcode 001 shifts right logically, and both refill vacated positions with 0. For a 4-bit word, 1100 shifted left by 2 gives 0000, and 1101 shifted right by 3 gives 0001.
- R2: Opcode 010 shifts left arithmetically and refills the vacated low positions with copies of the original bit 0. For a 4-bit word shifted by 1, 0111 gives 1111 and 1110 gives 1100.
- R3: Opcode 011 shifts right arithmetically and refills the vacated high positions with copies of the original bit WIDTH-1. For a 4-bit word, 1100 shifted by 1 gives 1110.
- R4: With a negative distance, a shift opcode performs the opposite-direction shift of the same kind. The fill rule is the one for the direction actually taken. For a 4-bit word, 1100 with opcode 011 and distance -1 gives 1000.
- R5: Opcode 100 rotates left and opcode 101 rotates right, and a negative distance rotates the other way. For a 4-bit word, 1100 rotated by 2 in either direction gives 0011. 1100 with opcode 100 and distance -1 gives 0110, and with opcode 101 and distance -1 gives 1001.
- R6: Opcodes 110 and 111 return the input word unchanged, whatever the distance.
- R7: For the four shift opcodes, a distance magnitude of WIDTH or more fills the whole word with the fill value of the direction taken.
- R8: For the rotate opcodes, the distance magnitude is reduced modulo WIDTH.
- R9: A distance of zero returns the input word unchanged for every opcode.
- R10: The distance port is $clog2(WIDTH)+2 bits wide and is read as two's complement. This includes its most negative value, which has a magnitude of twice WIDTH when WIDTH is a power of two.
- R11: With OUT_REG=1, the result appears on the output one clock after the inputs, and a synchronous active-high reset forces the output to zero. With OUT_REG=0, the output follows the inputs combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| data_in | input | WIDTH | Word to be moved |
| op | input | 3 | Mode select, encoded as listed in R1 to R6 |
| amount | input | $clog2(WIDTH)+2 | Signed two's complement shift or rotate distance |
| data_out | output | WIDTH | Moved word, registered when OUT_REG=1 |

## Verification
Directed 4-bit words with known answers check each mode's fill rule. Patterns such as 0111 against 1110 separate a zero fill from a low-bit fill, and 1100 separates a sign fill from a zero fill. Signed distances at -1, at exactly ±WIDTH, beyond ±WIDTH, and at the most negative code check the direction reversal, the saturation of shifts and the modulo reduction of rotates. These are the points where a swapped direction or an off-by-one bound gives a different word. Random words, opcodes and distances on a 16-bit registered instance are compared with a bit-by-bit reference model. Two reset phases check the output register.

// File: rtl/shf_pkg.sv
`timescale 1ns/1ps
package shf_pkg;
  // Mode group: bits [2:1] of the opcode select the kind, bit 0 the base direction
  typedef enum logic [1:0] {
    K_LOGIC = 2'b00,
    K_ARITH = 2'b01,
    K_ROT   = 2'b10,
    K_PASS  = 2'b11
  } shf_kind_e;

  function automatic shf_kind_e kind_of(input logic [2:0] op);
    case (op[2:1])
      2'b00:   return K_LOGIC;
      2'b01:   return K_ARITH;
      2'b10:   return K_ROT;
      default: return K_PASS;
    endcase
  endfunction
endpackage

// File: rtl/shf_amount_decode.sv
`timescale 1ns/1ps
module shf_amount_decode
  import shf_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int AMT_W = $clog2(WIDTH) + 2,
  parameter int ROT_W = $clog2(WIDTH),
  parameter int CNT_W = $clog2(WIDTH + 1)
) (
  input  logic [2:0]       op,
  input  logic [AMT_W-1:0] amount,
  output shf_kind_e        kind,
  output logic             go_left,
  output logic [ROT_W-1:0] rot_amt,
  output logic [CNT_W-1:0] mask_cnt
);
  localparam logic [AMT_W-1:0] W_A = AMT_W'(WIDTH);

  logic             neg;
  logic             sat;
  logic [AMT_W-1:0] mag;
  logic [AMT_W-1:0] k;

  always_comb begin
    neg     = amount[AMT_W-1];
    mag     = neg ? (~amount + 1'b1) : amount;
    kind    = kind_of(op);
    go_left = (~op[0]) ^ neg;
    sat     = (mag >= W_A);
    if (kind == K_ROT)       k = mag % W_A;
    else if (kind == K_PASS) k = '0;
    else if (sat)            k = '0;
    else                     k = mag;
    // Every move is turned into a left rotation by rot_amt
    if (go_left)             rot_amt = ROT_W'(k);
    else if (k == '0)        rot_amt = '0;
    else                     rot_amt = ROT_W'(W_A - k);
    if (kind == K_LOGIC || kind == K_ARITH)
      mask_cnt = sat ? CNT_W'(WIDTH) : CNT_W'(k);
    else
      mask_cnt = '0;
  end

  always_comb begin
    if (!$isunknown(amount) && !$isunknown(op)) begin
      assert_rot_below_width_R8: assert (int'(rot_amt) < WIDTH)
        else $error("rotation distance out of range");
      assert_mask_bounded_R7: assert (int'(mask_cnt) <= WIDTH)
        else $error("fill count exceeds width");
    end
  end
endmodule

// File: rtl/shf_rotator.sv
`timescale 1ns/1ps
module shf_rotator #(
  parameter int WIDTH = 16,
  parameter int ROT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] data_in,
  input  logic [ROT_W-1:0] rot_amt,
  output logic [WIDTH-1:0] rotated
);
  logic [WIDTH-1:0] stage [ROT_W+1];

  assign stage[0] = data_in;

  for (genvar i = 0; i < ROT_W; i++) begin : g_stage
    localparam int C = 1 << i;
    assign stage[i+1] = rot_amt[i]
      ? {stage[i][WIDTH-1-C:0], stage[i][WIDTH-1:WIDTH-C]}
      : stage[i];
  end

  assign rotated = stage[ROT_W];

  always_comb begin
    if (!$isunknown(data_in) && !$isunknown(rot_amt)) begin
      assert_rot_keeps_ones_R5: assert ($countones(rotated) == $countones(data_in))
        else $error("rotation lost or gained bits");
    end
  end
endmodule

// File: rtl/shf_fill_merge.sv
`timescale 1ns/1ps
module shf_fill_merge
  import shf_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int CNT_W = $clog2(WIDTH + 1)
) (
  input  logic [WIDTH-1:0] data_in,
  input  logic [WIDTH-1:0] rotated,
  input  shf_kind_e        kind,
  input  logic             go_left,
  input  logic [CNT_W-1:0] mask_cnt,
  output logic [WIDTH-1:0] result
);
  localparam logic [WIDTH-1:0] ONES = {WIDTH{1'b1}};

  logic             fill;
  logic [WIDTH-1:0] mask;

  always_comb begin
    if (kind == K_ARITH) fill = go_left ? data_in[0] : data_in[WIDTH-1];
    else                 fill = 1'b0;
    mask = go_left ? ~(ONES << mask_cnt) : ~(ONES >> mask_cnt);
    if (kind == K_PASS) result = data_in;
    else                result = (rotated & ~mask) | ({WIDTH{fill}} & mask);
  end

  always_comb begin
    if (!$isunknown(mask_cnt) && !$isunknown(kind) && !$isunknown(go_left)) begin
      assert_fill_count_R7: assert (($countones(mask)) == int'(mask_cnt))
        else $error("fill mask width mismatch");
    end
  end
endmodule

// File: rtl/shifter_six_mode.sv
`timescale 1ns/1ps
module shifter_six_mode
  import shf_pkg::*;
#(
  parameter int WIDTH   = 16,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [WIDTH-1:0]            data_in,
  input  logic [2:0]                  op,
  input  logic [$clog2(WIDTH)+1:0]    amount,
  output logic [WIDTH-1:0]            data_out
);
  localparam int AMT_W = $clog2(WIDTH) + 2;
  localparam int ROT_W = $clog2(WIDTH);
  localparam int CNT_W = $clog2(WIDTH + 1);

  shf_kind_e        kind;
  logic             go_left;
  logic [ROT_W-1:0] rot_amt;
  logic [CNT_W-1:0] mask_cnt;
  logic [WIDTH-1:0] rotated;
  logic [WIDTH-1:0] result_c;

  shf_amount_decode #(
    .WIDTH(WIDTH), .AMT_W(AMT_W), .ROT_W(ROT_W), .CNT_W(CNT_W)
  ) u_decode (
    .op(op), .amount(amount), .kind(kind), .go_left(go_left),
    .rot_amt(rot_amt), .mask_cnt(mask_cnt)
  );

  shf_rotator #(.WIDTH(WIDTH), .ROT_W(ROT_W)) u_rotate (
    .data_in(data_in), .rot_amt(rot_amt), .rotated(rotated)
  );

  shf_fill_merge #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_merge (
    .data_in(data_in), .rotated(rotated), .kind(kind), .go_left(go_left),
    .mask_cnt(mask_cnt), .result(result_c)
  );

  if (OUT_REG) begin : g_reg
    logic [WIDTH-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= result_c;
    end
    assign data_out = q;

    assert_reg_latency_R11: assert property (@(posedge clk) disable iff (rst)
      !$isunknown(result_c) |=> data_out == $past(result_c))
      else $error("output register latency broken");
    assert_reg_reset_R11: assert property (@(posedge clk)
      rst |=> data_out == '0)
      else $error("output not cleared by reset");
  end else begin : g_comb
    assign data_out = result_c;
  end

  assert_pass_codes_R6: assert property (@(posedge clk) disable iff (rst)
    (op[2:1] == 2'b11) |-> result_c == data_in)
    else $error("pass-through opcode altered the word");
  assert_zero_identity_R9: assert property (@(posedge clk) disable iff (rst)
    (amount == '0 && !$isunknown(data_in)) |-> result_c == data_in)
    else $error("zero distance altered the word");
endmodule

// File: tb/shifter_six_mode_tb.sv
`timescale 1ns/1ps
module shifter_six_mode_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] d16 = '0;
  logic [2:0]  op16 = '0;
  logic [5:0]  amt16 = '0;
  logic [15:0] q16;
  logic [3:0]  d4 = '0;
  logic [2:0]  op4 = '0;
  logic [3:0]  amt4 = '0;
  logic [3:0]  q4;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  shifter_six_mode #(.WIDTH(16), .OUT_REG(1'b1)) u_dut (
    .clk(clk), .rst(rst), .data_in(d16), .op(op16), .amount(amt16), .data_out(q16)
  );

  shifter_six_mode #(.WIDTH(4), .OUT_REG(1'b0)) u_dut4 (
    .clk(clk), .rst(rst), .data_in(d4), .op(op4), .amount(amt4), .data_out(q4)
  );

  // Reference model: bit-by-bit from the requirements
  function automatic logic [15:0] ref_fn(input logic [15:0] x, input logic [2:0] op,
                                         input int amt, input int n);
    logic [15:0] r;
    bit left;
    int m;
    int k;
    logic fill;
    r = '0;
    if (op[2:1] == 2'b11 || amt == 0) begin
      for (int j = 0; j < n; j++) r[j] = x[j];
      return r;
    end
    left = (op[0] == 1'b0);
    if (amt < 0) begin left = !left; m = -amt; end
    else m = amt;
    if (op[2]) begin
      k = m % n;
      for (int j = 0; j < n; j++)
        r[j] = left ? x[(j - k + n) % n] : x[(j + k) % n];
    end else begin
      fill = op[1] ? (left ? x[0] : x[n-1]) : 1'b0;
      for (int j = 0; j < n; j++) begin
        if (left) r[j] = (j >= m) ? x[j-m] : fill;
        else      r[j] = (j + m < n) ? x[j+m] : fill;
      end
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // 4-bit combinational instance: drive at negedge, sample 1 ns later
  task automatic vec4(input string tag, input logic [3:0] x, input logic [2:0] op,
                      input int amt, input logic [3:0] exp);
    @(negedge clk);
    d4 = x; op4 = op; amt4 = 4'(amt);
    #1;
    check(tag, {12'h0, q4}, {12'h0, exp});
  endtask

  // 16-bit registered instance: drive at negedge, sample after the next rising edge
  task automatic vec16(input string tag, input logic [15:0] x, input logic [2:0] op,
                       input int amt);
    logic [15:0] exp;
    exp = ref_fn(x, op, amt, 16);
    @(negedge clk);
    d16 = x; op16 = op; amt16 = 6'(amt);
    @(posedge clk);
    #1;
    check(tag, q16, exp);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    d16 = 16'hA5C3; op16 = 3'b100; amt16 = 6'd3;
    repeat (2) @(posedge clk);
    #1;
    check("R11 reset clears output", q16, 16'h0000);
    @(negedge clk);
    rst = 1'b0;

    // Directed 4-bit corner cases
    vec4("R1 lsl 1100 by 2", 4'b1100, 3'b000, 2, 4'b0000);
    vec4("R1 lsr 1101 by 3", 4'b1101, 3'b001, 3, 4'b0001);
    vec4("R2 asl 0111 by 1", 4'b0111, 3'b010, 1, 4'b1111);
    vec4("R2 asl 1110 by 1", 4'b1110, 3'b010, 1, 4'b1100);
    vec4("R3 asr 1100 by 1", 4'b1100, 3'b011, 1, 4'b1110);
    vec4("R4 asr 1100 by -1", 4'b1100, 3'b011, -1, 4'b1000);
    vec4("R4 lsl 1011 by -2", 4'b1011, 3'b000, -2, 4'b0010);
    vec4("R5 rol 1100 by 2", 4'b1100, 3'b100, 2, 4'b0011);
    vec4("R5 ror 1100 by 2", 4'b1100, 3'b101, 2, 4'b0011);
    vec4("R5 rol 1100 by -1", 4'b1100, 3'b100, -1, 4'b0110);
    vec4("R5 ror 1100 by -1", 4'b1100, 3'b101, -1, 4'b1001);
    vec4("R6 op 110 passes", 4'b1010, 3'b110, 3, 4'b1010);
    vec4("R6 op 111 passes", 4'b0110, 3'b111, -5, 4'b0110);
    vec4("R7 asr 1000 by 4", 4'b1000, 3'b011, 4, 4'b1111);
    vec4("R7 asl 0001 by 7", 4'b0001, 3'b010, 7, 4'b1111);
    vec4("R7 lsr 1111 by -4 (left)", 4'b1111, 3'b001, -4, 4'b0000);
    vec4("R8 rol 1000 by 5", 4'b1000, 3'b100, 5, 4'b0001);
    vec4("R8 ror 0001 by 6", 4'b0001, 3'b101, 6, 4'b0100);
    vec4("R9 asr zero", 4'b1001, 3'b011, 0, 4'b1001);
    vec4("R9 ror zero", 4'b1001, 3'b101, 0, 4'b1001);
    vec4("R10 most negative asr", 4'b0110, 3'b011, -8, 4'b0000);
    vec4("R10 most negative rol", 4'b0110, 3'b100, -8, 4'b0110);

    // Directed 16-bit corner cases through the output register
    vec16("R10 lsl by -32", 16'hFFFF, 3'b000, -32);
    vec16("R3 asr 8000 by 31", 16'h8000, 3'b011, 31);
    vec16("R8 rol by 17", 16'h8001, 3'b100, 17);
    vec16("R8 ror by -32", 16'h1234, 3'b101, -32);
    vec16("R7 lsr by 16", 16'hFFFF, 3'b001, 16);
    vec16("R2 asl by 15", 16'h0001, 3'b010, 15);
    for (int o = 0; o < 8; o++) vec16("R9 zero distance", 16'hC35A, 3'(o), 0);

    // Random 4-bit against the reference
    for (int i = 0; i < 300; i++) begin
      logic [3:0] x;
      logic [2:0] o;
      logic [3:0] a;
      x = 4'($urandom); o = 3'($urandom); a = 4'($urandom);
      vec4("R1-to-R10 random 4-bit", x, o, int'($signed(a)),
           ref_fn({12'h0, x}, o, int'($signed(a)), 4)[3:0]);
    end

    // Random 16-bit registered against the reference
    for (int i = 0; i < 600; i++) begin
      logic [5:0] a;
      a = 6'($urandom);
      vec16("R11 random 16-bit", 16'($urandom), 3'($urandom), int'($signed(a)));
    end

    // Reset asserted mid-run with live inputs
    @(negedge clk);
    d16 = 16'hFFFF; op16 = 3'b110; rst = 1'b1;
    @(posedge clk);
    #1;
    check("R11 reset mid-run", q16, 16'h0000);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    check("R11 resumes after reset", q16, 16'hFFFF);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule